// File: doc/BRIEF.md
# Three-Wire Serial Register Write Port

This block is a write-only slave for a three-wire control port: a select line, a serial clock and a serial data line. A host frames each access as sixteen bits sent most significant bit first. The block samples the data line on the rising edges of the serial clock. When a complete frame carries the right device address and the write flag, it stores the data byte into one of thirty-two eight-bit registers. The whole register bank is presented on a flat parallel output so that surrounding logic can use any field directly.

All three serial lines are resynchronised into the system clock domain by two-flop synchronizers. Rising edges of the serial clock are then found by comparing successive synchronised samples. The system clock must run at least four times faster than the serial clock. A static strap input picks the active level of the select line and the device address that frames must carry. An active-low power-down input, like the synchronous reset, returns every register to zero. Each committed write is also announced by a one-cycle strobe that carries the address and the byte.

Top module: `ser3w_reg_bank`

## Requirements
- R1: Frame bits, first to last, are: device address (2 bits, first bit is bit 1), write flag (1 bit), register address (5 bits, MSB first), data byte (8 bits, MSB first); a valid frame stores the byte into the register at that address.
- R2: The data line is taken only at serial clock rising edges; changes while the serial clock is high or low between edges have no effect.
- R3: A frame is committed on the sixteenth rising edge after select becomes active; `wr_stb` is high for exactly one system cycle, in the third system cycle after the raw serial clock rises, and carries the address on `wr_addr` and the byte on `wr_data`.
- R4: With `strap_pol` = 0, select is active when `sel_in` is 0 and the required device address is binary 10.
- R5: With `strap_pol` = 1, select is active when `sel_in` is 1 and the required device address is binary 01.
- R6: A frame whose device address differs from the strap-selected value causes no strobe and changes no register.
- R7: A frame whose write flag is 0 causes no strobe and changes no register.
- R8: Deasserting select before sixteen rising edges discards the partial frame; the next frame is received from its first bit.
- R9: Rising edges after the sixteenth are ignored until select is deasserted and asserted again.
- R10: While `pwr_dn_n` is 0 all registers read zero and no strobe is produced.
- R11: After synchronous reset all registers read zero and `wr_stb` is 0.
- R12: Register n appears on `reg_flat[8n+7:8n]`; a write changes only that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn_n | input | 1 | Active-low power-down, clears the bank and the receiver |
| strap_pol | input | 1 | Select polarity and device address selector |
| sel_in | input | 1 | Serial select line |
| sclk_in | input | 1 | Serial clock line |
| sdat_in | input | 1 | Serial data line |
| reg_flat | output | 256 | All thirty-two registers, register n at bits 8n+7..8n |
| wr_stb | output | 1 | One-cycle pulse for each committed write |
| wr_addr | output | 5 | Register address of the committed write |
| wr_data | output | 8 | Data byte of the committed write |

## Verification
Valid frames at the lowest, highest and middle addresses with contrasting byte values confirm bit order and the byte placement on the flat output. Frames with each wrong device address, a cleared write flag, a truncated length and trailing extra edges show that only a full, matching write frame commits, and that it commits on its sixteenth edge. A frame with the data line toggled while the serial clock is high separates edge sampling from level sampling. Repeating valid and invalid frames after flipping the strap separates the two polarity and address pairings, and a power-down pulse between writes shows the clear and the recovery.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;

    localparam int FRAME_W = 16;
    localparam int CHIP_W  = 2;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int NREG    = 1 << ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [CHIP_W-1:0] chip;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // Strap low expects 2'b10, strap high expects 2'b01.
    function automatic logic [CHIP_W-1:0] chip_for_strap(input logic strap);
        return {~strap, strap};
    endfunction

    // The select line is active when it equals the strap level.
    function automatic logic sel_active(input logic sel, input logic strap);
        return sel == strap;
    endfunction

endpackage

// File: rtl/ser3w_sync.sv
module ser3w_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/ser3w_rx.sv
module ser3w_rx
    import ser3w_pkg::*;
(
    input  logic    clk,
    input  logic    clr,
    input  logic    strap_pol,
    input  logic    sel_s,
    input  logic    sclk_s,
    input  logic    sdat_s,
    output logic    wr_stb,
    output wr_req_t wr_req
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    logic                 sclk_d;
    logic [CNT_W-1:0]     cnt;
    logic [FRAME_W-2:0]   shreg;
    logic                 rise;
    logic                 act;
    logic                 last_edge;
    logic                 frame_ok;
    frame_t               fr;

    assign rise      = sclk_s & ~sclk_d;
    assign act       = sel_active(sel_s, strap_pol);
    assign fr        = frame_t'({shreg, sdat_s});
    assign last_edge = act && rise && (cnt == CNT_LAST);
    assign frame_ok  = fr.wr && (fr.chip == chip_for_strap(strap_pol));

    always_ff @(posedge clk) begin
        if (clr) begin
            sclk_d <= 1'b0;
            cnt    <= '0;
            shreg  <= '0;
            wr_stb <= 1'b0;
            wr_req <= '0;
        end else begin
            sclk_d <= sclk_s;
            wr_stb <= last_edge && frame_ok;
            if (last_edge && frame_ok) begin
                wr_req.addr <= fr.addr;
                wr_req.data <= fr.data;
            end
            if (!act) begin
                cnt <= '0;
            end else if (rise && (cnt != CNT_FULL)) begin
                cnt   <= cnt + 1'b1;
                shreg <= {shreg[FRAME_W-3:0], sdat_s};
            end
        end
    end

endmodule

// File: rtl/ser3w_bank.sv
module ser3w_bank #(
    parameter int NR = 32,
    parameter int AW = 5,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [NR*DW-1:0] flat
);

    for (genvar i = 0; i < NR; i++) begin : g_reg
        logic [DW-1:0] r;
        always_ff @(posedge clk) begin
            if (clr)                                      r <= '0;
            else if (wr_en && (wr_addr == AW'(i)))        r <= wr_data;
        end
        assign flat[i*DW +: DW] = r;
    end

endmodule

// File: rtl/ser3w_reg_bank.sv
module ser3w_reg_bank
    import ser3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pwr_dn_n,
    input  logic                   strap_pol,
    input  logic                   sel_in,
    input  logic                   sclk_in,
    input  logic                   sdat_in,
    output logic [NREG*DATA_W-1:0] reg_flat,
    output logic                   wr_stb,
    output logic [ADDR_W-1:0]      wr_addr,
    output logic [DATA_W-1:0]      wr_data
);

    logic [2:0] pins_s;
    logic       clr;
    wr_req_t    req;

    assign clr = rst | ~pwr_dn_n;

    ser3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sel_in, sclk_in, sdat_in}),
        .q   (pins_s)
    );

    ser3w_rx u_rx (
        .clk       (clk),
        .clr       (clr),
        .strap_pol (strap_pol),
        .sel_s     (pins_s[2]),
        .sclk_s    (pins_s[1]),
        .sdat_s    (pins_s[0]),
        .wr_stb    (wr_stb),
        .wr_req    (req)
    );

    ser3w_bank #(.NR(NREG), .AW(ADDR_W), .DW(DATA_W)) u_bank (
        .clk     (clk),
        .clr     (clr),
        .wr_en   (wr_stb),
        .wr_addr (req.addr),
        .wr_data (req.data),
        .flat    (reg_flat)
    );

    assign wr_addr = req.addr;
    assign wr_data = req.data;

endmodule

// File: rtl/ser3w_chk.sv
module ser3w_chk
    import ser3w_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   pwr_dn_n,
    input logic                   strap_pol,
    input logic                   sel_in,
    input logic [NREG*DATA_W-1:0] reg_flat,
    input logic                   wr_stb,
    input logic [ADDR_W-1:0]      wr_addr,
    input logic [DATA_W-1:0]      wr_data
);

    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        idle_cnt;
    logic [DATA_W-1:0] byte_at;

    always_ff @(posedge clk) begin
        addr_q <= wr_addr;
        if (rst)                          idle_cnt <= '0;
        else if (sel_in == strap_pol)     idle_cnt <= '0;
        else if (idle_cnt != 2'd3)        idle_cnt <= idle_cnt + 2'd1;
    end

    assign byte_at = reg_flat[{addr_q, 3'b000} +: DATA_W];

    // R3
    stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R1
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && pwr_dn_n) |=> (byte_at == $past(wr_data)));

    // R10
    pdn_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_dn_n |=> (reg_flat == '0 && !wr_stb));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_cnt == 2'd3) |-> !wr_stb);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_stb && pwr_dn_n) |=> $stable(reg_flat));

endmodule

bind ser3w_reg_bank ser3w_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_dn_n  (pwr_dn_n),
    .strap_pol (strap_pol),
    .sel_in    (sel_in),
    .reg_flat  (reg_flat),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
);

// File: tb/sim_ser3w_reg_bank.sv
module sim_ser3w_reg_bank;

    localparam int H = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pwr_dn_n = 1'b1;
    logic         strap_pol = 1'b0;
    logic         sel_in = 1'b1;
    logic         sclk_in = 1'b0;
    logic         sdat_in = 1'b0;
    logic [255:0] reg_flat;
    logic         wr_stb;
    logic [4:0]   wr_addr;
    logic [7:0]   wr_data;

    int n_tests = 0;
    int n_fail  = 0;

    logic [12:0] exp_q [$];
    logic [7:0]  model [32];

    always #2.5 clk = ~clk;

    ser3w_reg_bank u0 (
        .clk       (clk),
        .rst       (rst),
        .pwr_dn_n  (pwr_dn_n),
        .strap_pol (strap_pol),
        .sel_in    (sel_in),
        .sclk_in   (sclk_in),
        .sdat_in   (sdat_in),
        .reg_flat  (reg_flat),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [255:0] model_flat();
        logic [255:0] f;
        for (int i = 0; i < 32; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    // Scoreboard monitor: each strobe must match the oldest expected write.
    always @(negedge clk) begin
        if (!rst && wr_stb) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "strobe with nothing expected", {243'd0, wr_addr, wr_data}, '0);
            end else begin
                logic [12:0] e;
                e = exp_q.pop_front();
                check({wr_addr, wr_data} == e, "R3", "strobe address/data",
                      {243'd0, wr_addr, wr_data}, {243'd0, e});
            end
        end
    end

    task automatic set_strap(input logic s);
        strap_pol = s;
        sel_in    = ~s;
        waitn(6);
    endtask

    task automatic send_frame(input logic [1:0] chip, input logic rw,
                              input logic [4:0] addr, input logic [7:0] data,
                              input int nbits, input int extra, input bit glitch,
                              input string req);
        logic [15:0] w;
        bit          valid;
        w     = {chip, rw, addr, data};
        valid = (nbits >= 16) && (chip == {~strap_pol, strap_pol}) && rw;
        if (valid) begin
            exp_q.push_back({addr, data});
            model[addr] = data;
        end
        sel_in = strap_pol;
        waitn(H);
        for (int i = 0; i < nbits + extra; i++) begin
            sdat_in = (i < 16) ? w[15-i] : 1'($urandom);
            waitn(H);
            sclk_in = 1'b1;
            for (int k = 1; k <= H; k++) begin
                @(negedge clk);
                if (glitch && k == 2) sdat_in = ~sdat_in;
                if (i == 15)
                    check(wr_stb == (valid && k == 3), req, "strobe timing",
                          {255'd0, wr_stb}, {255'd0, (valid && k == 3)});
            end
            sclk_in = 1'b0;
        end
        waitn(H);
        sel_in = ~strap_pol;
        waitn(8);
    endtask

    task automatic check_bank(input string req);
        check(reg_flat == model_flat(), req, "register bank", reg_flat, model_flat());
        check(exp_q.size() == 0, req, "pending writes", 256'(exp_q.size()), '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        waitn(4);
        rst = 1'b0;
        waitn(4);
        // R11 reset state
        check(reg_flat == '0, "R11", "bank after reset", reg_flat, '0);
        check(wr_stb == 1'b0, "R11", "strobe after reset", {255'd0, wr_stb}, '0);

        // R4 strap low, chip 10; R1 and R12 byte placement
        set_strap(1'b0);
        send_frame(2'b10, 1'b1, 5'd3,  8'hA5, 16, 0, 0, "R4");
        check_bank("R1");
        send_frame(2'b10, 1'b1, 5'd31, 8'h3C, 16, 0, 0, "R12");
        send_frame(2'b10, 1'b1, 5'd0,  8'hFF, 16, 0, 0, "R12");
        check_bank("R12");

        // R6 wrong device addresses
        send_frame(2'b01, 1'b1, 5'd5, 8'h11, 16, 0, 0, "R6");
        send_frame(2'b11, 1'b1, 5'd5, 8'h22, 16, 0, 0, "R6");
        send_frame(2'b00, 1'b1, 5'd3, 8'h33, 16, 0, 0, "R6");
        check_bank("R6");

        // R7 read flag
        send_frame(2'b10, 1'b0, 5'd3, 8'h44, 16, 0, 0, "R7");
        check_bank("R7");

        // R8 truncated frame, then a full one
        send_frame(2'b10, 1'b1, 5'd7, 8'h55, 10, 0, 0, "R8");
        check_bank("R8");
        send_frame(2'b10, 1'b1, 5'd7, 8'h66, 16, 0, 0, "R8");
        check_bank("R8");

        // R9 trailing edges
        send_frame(2'b10, 1'b1, 5'd12, 8'h5A, 16, 6, 0, "R9");
        check_bank("R9");

        // R2 data toggled while serial clock high
        send_frame(2'b10, 1'b1, 5'd20, 8'hC3, 16, 0, 1, "R2");
        check_bank("R2");

        // R5 strap high, chip 01 accepted, 10 rejected
        set_strap(1'b1);
        send_frame(2'b01, 1'b1, 5'd9,  8'h96, 16, 0, 0, "R5");
        send_frame(2'b10, 1'b1, 5'd9,  8'h00, 16, 0, 0, "R5");
        send_frame(2'b01, 1'b1, 5'd17, 8'h81, 16, 0, 0, "R5");
        check_bank("R5");

        // R10 power-down
        pwr_dn_n = 1'b0;
        waitn(3);
        check(reg_flat == '0, "R10", "bank in power-down", reg_flat, '0);
        check(wr_stb == 1'b0, "R10", "strobe in power-down", {255'd0, wr_stb}, '0);
        pwr_dn_n = 1'b1;
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
        waitn(4);
        check_bank("R10");
        send_frame(2'b01, 1'b1, 5'd1, 8'h7E, 16, 0, 0, "R10");
        check_bank("R1");

        report();
    end

endmodule